// File: doc/BRIEF.md
# Character wait-time watchdog

This block watches the receive side of a half-duplex smart-card serial line. It measures the silence that follows each received character and flags it when the silence lasts too long. A bit-level receiver supplies a one-cycle pulse per completed character. A timing generator supplies a one-cycle pulse per elementary time unit (ETU). The host programs an 8-bit wait limit and a rate factor D of 1 or 8.

One wait unit is 960 × D ETU ticks. A prescaler counts ETU ticks up to the unit length, and a unit counter counts the completed units. The watchdog expires on the tick that completes unit number limit + 1, so the silence has gone past the limit. Expiry sets a sticky overflow flag. A host read of the interrupt status clears the flag. A mask input gates the interrupt line but leaves the flag alone. After an expiry the watchdog stays quiet until a new character restarts the count. Clearing the enable also holds it at zero.

Top module: `char_wait_watchdog`

## Requirements
- R1: After reset, `wt_flag` and `wt_irq` are 0 and the measured gap is zero.
- R2: With `rate_sel` = 0 (D = 1), `wt_flag` rises on the clock edge that samples ETU tick number (`wait_limit` + 1) × 960 after the last restart, and not earlier.
- R3: With `rate_sel` = 1 (D = 8), the expiry tick number is (`wait_limit` + 1) × 7680.
- R4: A `char_rx` pulse restarts the gap measurement from zero. The timeout is then counted again in full from the cycle after the pulse.
- R5: While `enable` is 0 the gap is held at zero and no expiry occurs, whatever `etu_tick` does. When `enable` returns to 1, counting starts again from zero.
- R6: An expiry happens only once per gap. After the flag has been cleared, it does not set again until a `char_rx` pulse or a disable restarts the count.
- R7: `wt_flag` stays at 1 until a cycle with `flag_rd` = 1, and it reads 0 after that cycle. If an expiry and `flag_rd` fall in the same cycle, the flag ends up at 1.
- R8: `wt_irq` is 1 exactly when `wt_flag` is 1 and `irq_mask` is 0. `irq_mask` has no effect on `wt_flag`.
- R9: A `char_rx` pulse in the same cycle as the tick that would expire suppresses the expiry and restarts the count.
- R10: Only cycles with `etu_tick` = 1 advance the measurement. Cycles without a tick leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| etu_tick | input | 1 | One-cycle pulse per elementary time unit |
| char_rx | input | 1 | One-cycle pulse per received character |
| enable | input | 1 | Watchdog enable |
| wait_limit | input | 8 | Programmed limit in wait units |
| rate_sel | input | 1 | Rate factor: 0 selects D = 1, 1 selects D = 8 |
| flag_rd | input | 1 | Host read strobe of the interrupt status; clears the flag |
| irq_mask | input | 1 | 1 suppresses the interrupt output |
| wt_flag | output | 1 | Sticky wait-time overflow flag |
| wt_irq | output | 1 | Masked interrupt request |

## Verification
A wrong internal state shows at the ports as a shifted expiry. Say the prescaler or unit counter slips by one, misses a restart, or keeps counting while disabled. Then `wt_flag` rises one or more ticks early or late, or rises where it should stay low. That shows up at the exact edge the reference model predicts, within one wait unit at most. A bad expiry latch shows as a second flag in the same gap after a host clear. A priority error shows in the same cycle as the colliding `char_rx` or `flag_rd`. A mask fault shows on `wt_irq` at once.

// File: rtl/char_wait_watchdog.sv
module char_wait_watchdog #(
  parameter int LIMIT_W      = 8,
  parameter int ETU_PER_UNIT = 960,
  parameter int D_HIGH       = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               etu_tick,
  input  logic               char_rx,
  input  logic               enable,
  input  logic [LIMIT_W-1:0] wait_limit,
  input  logic               rate_sel,
  input  logic               flag_rd,
  input  logic               irq_mask,
  output logic               wt_flag,
  output logic               wt_irq
);

  localparam int UNIT_HI = ETU_PER_UNIT * D_HIGH;
  localparam int PRE_W   = $clog2(UNIT_HI);

  logic [PRE_W-1:0]   pre_cnt;
  logic [LIMIT_W-1:0] unit_cnt;
  logic               armed;

  wire [PRE_W-1:0] pre_max  = rate_sel ? PRE_W'(UNIT_HI - 1) : PRE_W'(ETU_PER_UNIT - 1);
  wire             counting = enable & armed & etu_tick & ~char_rx;
  wire             unit_end = counting & (pre_cnt >= pre_max);
  wire             expire   = unit_end & (unit_cnt == wait_limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      unit_cnt <= '0;
      armed    <= 1'b1;
    end else if (char_rx || !enable) begin
      pre_cnt  <= '0;
      unit_cnt <= '0;
      armed    <= 1'b1;
    end else if (expire) begin
      pre_cnt  <= '0;
      unit_cnt <= '0;
      armed    <= 1'b0;
    end else if (unit_end) begin
      pre_cnt  <= '0;
      unit_cnt <= unit_cnt + 1'b1;
    end else if (counting) begin
      pre_cnt  <= pre_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wt_flag <= 1'b0;
    else if (expire)  wt_flag <= 1'b1;
    else if (flag_rd) wt_flag <= 1'b0;
  end

  assign wt_irq = wt_flag & ~irq_mask;

  assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    char_rx |=> (pre_cnt == '0 && unit_cnt == '0 && armed));

  assert_disabled_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (pre_cnt == '0 && unit_cnt == '0 && !expire));

  assert_single_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (!armed && wt_flag));

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wt_flag && !flag_rd) |=> wt_flag);

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && !expire) |=> !wt_flag);

  assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wt_irq |-> wt_flag);

  assert_idle_no_advance_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!etu_tick && enable && !char_rx) |=> ($stable(pre_cnt) && $stable(unit_cnt)));

endmodule

// File: tb/tb_char_wait_watchdog.sv
module tb_char_wait_watchdog;
  logic clk = 0, rst_n = 0;
  logic etu_tick = 0, char_rx = 0, enable = 0, rate_sel = 0, flag_rd = 0, irq_mask = 0;
  logic [7:0] wait_limit = 8'd0;
  logic wt_flag, wt_irq;

  int checks = 0, fails = 0;
  bit go = 0, done = 0;

  int  gap = 0;
  bit  fired = 0, m_flag = 0;

  always #5 clk = ~clk;

  char_wait_watchdog dut (
    .clk(clk), .rst_n(rst_n), .etu_tick(etu_tick), .char_rx(char_rx),
    .enable(enable), .wait_limit(wait_limit), .rate_sel(rate_sel),
    .flag_rd(flag_rd), .irq_mask(irq_mask), .wt_flag(wt_flag), .wt_irq(wt_irq)
  );

  always @(posedge clk) begin
    bit ev;
    int need;
    ev = 0;
    need = (int'(wait_limit) + 1) * 960 * (rate_sel ? 8 : 1);
    if (!rst_n) begin
      gap = 0; fired = 0; m_flag = 0;
    end else begin
      if (char_rx || !enable) begin
        gap = 0; fired = 0;
      end else if (etu_tick && !fired) begin
        gap++;
        if (gap == need) begin ev = 1; fired = 1; gap = 0; end
      end
      if (ev) m_flag = 1;
      else if (flag_rd) m_flag = 0;
    end
  end

  always @(negedge clk) begin
    if (go) begin
      checks++;
      if (wt_flag !== m_flag) begin
        fails++;
        $display("FAIL R7 model flag: actual %b expected %b at %0t", wt_flag, m_flag, $time);
      end
      checks++;
      if (wt_irq !== (m_flag & ~irq_mask)) begin
        fails++;
        $display("FAIL R8 model irq: actual %b expected %b at %0t", wt_irq, m_flag & ~irq_mask, $time);
      end
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit t, input bit c, input bit r);
    etu_tick = t; char_rx = c; flag_rd = r;
    @(posedge clk);
    @(negedge clk);
    etu_tick = 0; char_rx = 0; flag_rd = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0);
  endtask

  task automatic restart(input logic [7:0] lim, input bit rs);
    wait_limit = lim; rate_sel = rs;
    cyc(0, 0, 1);
    cyc(0, 1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    go = 1;
    chk("R1 flag after reset", wt_flag, 1'b0);
    chk("R1 irq after reset", wt_irq, 1'b0);
    enable = 1;

    restart(8'd1, 0);
    ticks(1919);
    chk("R2 no flag one tick early", wt_flag, 1'b0);
    ticks(1);
    chk("R2 flag at limit+1 units", wt_flag, 1'b1);
    chk("R8 irq with mask clear", wt_irq, 1'b1);
    irq_mask = 1;
    #1;
    chk("R8 mask hides irq", wt_irq, 1'b0);
    chk("R8 mask keeps flag", wt_flag, 1'b1);
    irq_mask = 0;
    cyc(0, 0, 0);
    chk("R7 flag sticky", wt_flag, 1'b1);
    cyc(0, 0, 1);
    chk("R7 read clears flag", wt_flag, 1'b0);
    ticks(3000);
    chk("R6 no second event in same gap", wt_flag, 1'b0);

    restart(8'd0, 0);
    ticks(959);
    cyc(1, 0, 1);
    chk("R7 set wins over read", wt_flag, 1'b1);

    restart(8'd0, 1);
    ticks(7679);
    chk("R3 no flag one tick early", wt_flag, 1'b0);
    ticks(1);
    chk("R3 flag at 7680 ticks", wt_flag, 1'b1);

    restart(8'd0, 0);
    ticks(900);
    cyc(0, 1, 0);
    ticks(900);
    chk("R4 restart extends timeout", wt_flag, 1'b0);
    ticks(59);
    chk("R4 still counting", wt_flag, 1'b0);
    ticks(1);
    chk("R4 full timeout after restart", wt_flag, 1'b1);

    restart(8'd0, 0);
    ticks(959);
    cyc(1, 1, 0);
    chk("R9 char on final tick suppresses", wt_flag, 1'b0);
    ticks(959);
    chk("R9 count restarted", wt_flag, 1'b0);
    ticks(1);
    chk("R9 flag after fresh gap", wt_flag, 1'b1);

    cyc(0, 0, 1);
    enable = 0;
    ticks(5000);
    chk("R5 disabled no event", wt_flag, 1'b0);
    enable = 1;
    ticks(959);
    chk("R5 count starts at zero", wt_flag, 1'b0);
    ticks(1);
    chk("R5 flag after re-enable", wt_flag, 1'b1);

    restart(8'd0, 0);
    for (int i = 0; i < 959; i++) begin cyc(0, 0, 0); cyc(0, 0, 0); cyc(1, 0, 0); end
    cyc(0, 0, 0);
    chk("R10 idle cycles do not count", wt_flag, 1'b0);
    cyc(1, 0, 0);
    chk("R10 flag at 960th tick", wt_flag, 1'b1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule